// File: doc/BRIEF.md
# Truth-Table Fitness Evaluator

This block scores one candidate combinational circuit against a target truth table. After a start request it walks every primary input combination, drives each one onto the candidate, reads the expected outputs for the same combination from an external truth-table memory, and counts the output bits that agree. The counted agreement is the functionality score. Its maximum is the number of table rows times the number of outputs.

The score has two phases. A circuit that misses any bit reports only its agreement count. A circuit that matches every bit also receives a simplicity bonus equal to the number of pass-through (wire) cells in its layout. That wire count is captured when the evaluation starts. A one-cycle completion pulse comes with the final score and a flag that marks a fully functional candidate. A search engine around the block uses the score to rank candidates.

Top module: `tt_fitness_eval`

## Requirements
- R1: While reset is asserted and in the first cycle after it, busy_o, done_o, functional_o, fitness_o, vec_o and tt_addr_o are all 0.
- R2: A start_i seen high while idle makes busy_o high from the next cycle. vec_o then steps through 0 to 2^NUM_IN-1 in ascending order, and each value is held for two cycles: an apply cycle followed by a sample cycle. tt_addr_o always equals vec_o. While idle, vec_o is 0.
- R3: The truth-table memory has one cycle of read latency. In the sample cycle of each vector, the block compares cand_i with tt_data_i bit by bit and adds the number of equal bits to the functionality score f1.
- R4: If f1 is below F10 = 2^NUM_IN × NUM_OUT at the end of the run, fitness_o equals f1 and functional_o is 0.
- R5: If f1 equals F10, fitness_o equals F10 plus the wire_cnt_i value sampled in the accepted start cycle, and functional_o is 1. Later changes on wire_cnt_i have no effect on the result.
- R6: done_o is high for exactly one cycle, 2 × 2^NUM_IN + 1 cycles after the cycle in which start was driven. busy_o is low in that cycle.
- R7: An accepted start clears fitness_o and functional_o. Otherwise both hold their value between runs.
- R8: start_i is ignored while busy_o is high. The vector walk, the completion time and the score are unchanged, and no second run follows.
- R9: The fitness output is wide enough for F10 plus the largest wire count, 2^WIRE_W-1, without wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request a new evaluation |
| wire_cnt_i | input | WIRE_W | Number of wire cells in the candidate |
| busy_o | output | 1 | Evaluation in progress |
| vec_o | output | NUM_IN | Input combination driven onto the candidate |
| cand_i | input | NUM_OUT | Candidate outputs for vec_o |
| tt_addr_o | output | NUM_IN | Truth-table memory read address |
| tt_data_i | input | NUM_OUT | Expected outputs, one cycle after the address |
| done_o | output | 1 | One-cycle completion pulse |
| functional_o | output | 1 | Every truth-table bit matched |
| fitness_o | output | FIT_W | Final fitness score |

## Verification
The vector and busy outputs move on the clock edge after the start is taken. Each vector is held for two cycles, and the score for a run of 2^NUM_IN vectors is due with done_o 2 × 2^NUM_IN + 1 cycles after start is driven. The bench runs a behavioural reference that advances on each rising edge from the same inputs. On every falling edge it compares every output against that reference, so each result is checked in the cycle it is due. Each run is also checked once it ends: the cycle count at which done_o appears and a score computed directly from the two tables.

// File: rtl/tt_fit_pkg.sv
package tt_fit_pkg;

    typedef enum logic [1:0] {
        EV_IDLE   = 2'd0,
        EV_APPLY  = 2'd1,
        EV_SAMPLE = 2'd2
    } ev_state_e;

endpackage

// File: rtl/tt_match_count.sv
module tt_match_count #(
    parameter int NUM_OUT = 2,
    parameter int CNT_W   = $clog2(NUM_OUT + 1)
) (
    input  logic [NUM_OUT-1:0] cand_bits,
    input  logic [NUM_OUT-1:0] want_bits,
    output logic [CNT_W-1:0]   agree_cnt
);

    logic [NUM_OUT-1:0] agree;

    genvar b;
    generate
        for (b = 0; b < NUM_OUT; b++) begin : g_agree
            assign agree[b] = ~(cand_bits[b] ^ want_bits[b]);
        end
    endgenerate

    always_comb begin
        agree_cnt = '0;
        for (int i = 0; i < NUM_OUT; i++) begin
            agree_cnt = agree_cnt + CNT_W'(agree[i]);
        end
    end

endmodule

// File: rtl/tt_score_merge.sv
module tt_score_merge #(
    parameter int F1_W   = 5,
    parameter int WIRE_W = 4,
    parameter int FIT_W  = 5,
    parameter int F_MAX  = 16
) (
    input  logic [F1_W-1:0]   f1_score,
    input  logic [WIRE_W-1:0] wire_cnt,
    output logic              all_match,
    output logic [FIT_W-1:0]  score
);

    always_comb begin
        all_match = (f1_score == F1_W'(F_MAX));
        if (all_match) begin
            score = FIT_W'(f1_score) + FIT_W'(wire_cnt);
        end else begin
            score = FIT_W'(f1_score);
        end
    end

endmodule

// File: rtl/tt_fitness_eval.sv
module tt_fitness_eval #(
    parameter int NUM_IN  = 3,
    parameter int NUM_OUT = 2,
    parameter int WIRE_W  = 4,
    localparam int N_VEC  = 1 << NUM_IN,
    localparam int F_MAX  = N_VEC * NUM_OUT,
    localparam int F1_W   = $clog2(F_MAX + 1),
    localparam int CNT_W  = $clog2(NUM_OUT + 1),
    localparam int FIT_W  = $clog2(F_MAX + (1 << WIRE_W))
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [WIRE_W-1:0]  wire_cnt_i,
    output logic               busy_o,
    output logic [NUM_IN-1:0]  vec_o,
    input  logic [NUM_OUT-1:0] cand_i,
    output logic [NUM_IN-1:0]  tt_addr_o,
    input  logic [NUM_OUT-1:0] tt_data_i,
    output logic               done_o,
    output logic               functional_o,
    output logic [FIT_W-1:0]   fitness_o
);
    import tt_fit_pkg::*;

    localparam logic [NUM_IN-1:0] LAST_VEC = '1;

    typedef struct packed {
        ev_state_e          st;
        logic [NUM_IN-1:0]  vec;
        logic [F1_W-1:0]    f1;
        logic [WIRE_W-1:0]  wires;
        logic               done;
        logic               func;
        logic [FIT_W-1:0]   fit;
    } ev_regs_t;

    ev_regs_t r_q, r_d;

    logic [CNT_W-1:0] agree_cnt;
    logic [F1_W-1:0]  f1_next;
    logic             merged_func;
    logic [FIT_W-1:0] merged_fit;

    tt_match_count #(
        .NUM_OUT (NUM_OUT),
        .CNT_W   (CNT_W)
    ) match_i (
        .cand_bits (cand_i),
        .want_bits (tt_data_i),
        .agree_cnt (agree_cnt)
    );

    assign f1_next = r_q.f1 + F1_W'(agree_cnt);

    tt_score_merge #(
        .F1_W   (F1_W),
        .WIRE_W (WIRE_W),
        .FIT_W  (FIT_W),
        .F_MAX  (F_MAX)
    ) merge_i (
        .f1_score  (f1_next),
        .wire_cnt  (r_q.wires),
        .all_match (merged_func),
        .score     (merged_fit)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.st)
            EV_IDLE: begin
                if (start_i) begin
                    r_d.st    = EV_APPLY;
                    r_d.vec   = '0;
                    r_d.f1    = '0;
                    r_d.wires = wire_cnt_i;
                    r_d.fit   = '0;
                    r_d.func  = 1'b0;
                end
            end
            EV_APPLY: begin
                r_d.st = EV_SAMPLE;
            end
            EV_SAMPLE: begin
                r_d.f1 = f1_next;
                if (r_q.vec == LAST_VEC) begin
                    r_d.st   = EV_IDLE;
                    r_d.vec  = '0;
                    r_d.done = 1'b1;
                    r_d.fit  = merged_fit;
                    r_d.func = merged_func;
                end else begin
                    r_d.st  = EV_APPLY;
                    r_d.vec = r_q.vec + 1'b1;
                end
            end
            default: begin
                r_d.st = EV_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{st: EV_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign busy_o       = (r_q.st != EV_IDLE);
    assign vec_o        = r_q.vec;
    assign tt_addr_o    = r_q.vec;
    assign done_o       = r_q.done;
    assign functional_o = r_q.func;
    assign fitness_o    = r_q.fit;

endmodule

// File: rtl/tt_fitness_eval_chk.sv
module tt_fitness_eval_chk #(
    parameter int NUM_IN  = 3,
    parameter int NUM_OUT = 2,
    parameter int WIRE_W  = 4,
    localparam int F_MAX  = (1 << NUM_IN) * NUM_OUT,
    localparam int FIT_W  = $clog2(F_MAX + (1 << WIRE_W))
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              busy_o,
    input logic [NUM_IN-1:0] vec_o,
    input logic              done_o,
    input logic              functional_o,
    input logic [FIT_W-1:0]  fitness_o
);

    // R6
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R6
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    // R5
    full_score_chk: assert property (@(posedge clk) disable iff (!rst_n)
        functional_o |-> (fitness_o >= FIT_W'(F_MAX)));

    // R4
    partial_score_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !functional_o) |-> (fitness_o < FIT_W'(F_MAX)));

    // R2
    vec_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |->
            (vec_o == $past(vec_o) || vec_o == NUM_IN'($past(vec_o) + 1'b1)));

    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> ($stable(fitness_o) && $stable(functional_o)));

endmodule

bind tt_fitness_eval tt_fitness_eval_chk #(
    .NUM_IN  (NUM_IN),
    .NUM_OUT (NUM_OUT),
    .WIRE_W  (WIRE_W)
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .busy_o       (busy_o),
    .vec_o        (vec_o),
    .done_o       (done_o),
    .functional_o (functional_o),
    .fitness_o    (fitness_o)
);

// File: tb/tt_fitness_eval_tb.sv
module tt_fitness_eval_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NI   = 3;
    localparam int NO   = 2;
    localparam int WW   = 4;
    localparam int NV   = 1 << NI;
    localparam int FMAX = NV * NO;
    localparam int FW   = $clog2(FMAX + (1 << WW));

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [WW-1:0] wire_cnt_i = '0;
    logic          busy_o;
    logic [NI-1:0] vec_o;
    logic [NO-1:0] cand_i;
    logic [NI-1:0] tt_addr_o;
    logic [NO-1:0] tt_data_i = '0;
    logic          done_o;
    logic          functional_o;
    logic [FW-1:0] fitness_o;

    logic [NO-1:0] tgt      [NV];
    logic [NO-1:0] cand_tab [NV];

    int checks = 0;
    int errors = 0;
    int cyc    = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tt_fitness_eval #(.NUM_IN(NI), .NUM_OUT(NO), .WIRE_W(WW)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .wire_cnt_i   (wire_cnt_i),
        .busy_o       (busy_o),
        .vec_o        (vec_o),
        .cand_i       (cand_i),
        .tt_addr_o    (tt_addr_o),
        .tt_data_i    (tt_data_i),
        .done_o       (done_o),
        .functional_o (functional_o),
        .fitness_o    (fitness_o)
    );

    // candidate circuit stand-in and table memory with one cycle of latency
    assign cand_i = cand_tab[vec_o];
    always @(posedge clk) tt_data_i <= tgt[tt_addr_o];

    function automatic int agree_bits(int v);
        int n = 0;
        for (int b = 0; b < NO; b++) if (cand_tab[v][b] == tgt[v][b]) n++;
        return n;
    endfunction

    function automatic int direct_f1();
        int s = 0;
        for (int v = 0; v < NV; v++) s += agree_bits(v);
        return s;
    endfunction

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // behavioural reference, advanced on every rising edge
    int ref_busy = 0, ref_cnt = 0, ref_f1 = 0, ref_wire = 0;
    int ref_fit = 0, ref_func = 0, ref_done = 0;

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            ref_busy = 0; ref_cnt = 0; ref_f1 = 0; ref_wire = 0;
            ref_fit = 0; ref_func = 0; ref_done = 0;
        end else begin
            ref_done = 0;
            if (ref_busy == 0) begin
                if (start_i) begin
                    ref_busy = 1; ref_cnt = 0; ref_f1 = 0;
                    ref_wire = int'(wire_cnt_i); ref_fit = 0; ref_func = 0;
                end
            end else begin
                if (ref_cnt % 2 == 1) ref_f1 += agree_bits(ref_cnt / 2);
                if (ref_cnt == 2 * NV - 1) begin
                    ref_busy = 0;
                    ref_done = 1;
                    ref_func = (ref_f1 == FMAX) ? 1 : 0;
                    ref_fit  = ref_func ? ref_f1 + ref_wire : ref_f1;
                end else begin
                    ref_cnt++;
                end
            end
        end
    end

    // per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            int exp_vec;
            string ftag;
            exp_vec = ref_busy ? ref_cnt / 2 : 0;
            ftag = ref_done ? (ref_func ? "R5" : "R4") : "R7";
            check("R2 busy", int'(busy_o), ref_busy);
            check("R2 vec", int'(vec_o), exp_vec);
            check("R2 addr", int'(tt_addr_o), exp_vec);
            check("R6 done", int'(done_o), ref_done);
            check({ftag, " functional"}, int'(functional_o), ref_func);
            check({ftag, " R3 fitness"}, int'(fitness_o), ref_fit);
        end
    end

    always @(posedge clk) begin
        if (cyc > 100000) begin
            errors++;
            checks++;
            $display("FAIL watchdog R6 actual=%0d expected<=%0d", cyc, 100000);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic run_eval(input logic [WW-1:0] w, input int extra_start,
                            input int wire_change, output int k_done);
        k_done = -1;
        @(negedge clk);
        start_i = 1'b1;
        wire_cnt_i = w;
        for (int k = 1; k <= 4 * NV + 20; k++) begin
            @(negedge clk);
            if (k == 1) start_i = 1'b0;
            if (k == extra_start) start_i = 1'b1;
            if (k == extra_start + 1) start_i = 1'b0;
            if (k == wire_change) wire_cnt_i = ~w;
            if (done_o) begin
                k_done = k;
                break;
            end
        end
    endtask

    task automatic scenario(string name, input logic [WW-1:0] w,
                            input int extra_start, input int wire_change);
        int kd, f1, exp_fit, exp_func;
        logic [FW-1:0] held;
        run_eval(w, extra_start, wire_change, kd);
        f1 = direct_f1();
        exp_func = (f1 == FMAX) ? 1 : 0;
        exp_fit  = exp_func ? f1 + int'(w) : f1;
        check({"R6 done timing ", name}, kd, 2 * NV + 1);
        check({exp_func ? "R5" : "R4", " R3 final score ", name}, int'(fitness_o), exp_fit);
        check({exp_func ? "R5" : "R4", " final flag ", name}, int'(functional_o), exp_func);
        held = fitness_o;
        repeat (4) @(negedge clk);
        check({"R7 hold ", name}, int'(fitness_o), int'(held));
        check({"R8 no rerun ", name}, int'(busy_o), 0);
    endtask

    initial begin
        for (int v = 0; v < NV; v++) begin
            tgt[v] = NO'((v * 5 + 3) ^ (v >> 1));
        end
        repeat (3) @(negedge clk);
        check("R1 busy", int'(busy_o), 0);
        check("R1 done", int'(done_o), 0);
        check("R1 fitness", int'(fitness_o), 0);
        check("R1 vec", int'(vec_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 functional after reset", int'(functional_o), 0);
        check("R1 addr after reset", int'(tt_addr_o), 0);

        // exact candidate: full score plus wires
        for (int v = 0; v < NV; v++) cand_tab[v] = tgt[v];
        scenario("exact", 4'd5, -1, -1);

        // one bit wrong in the last row
        cand_tab[NV-1][0] = ~tgt[NV-1][0];
        scenario("one miss", 4'd9, -1, -1);

        // every bit wrong
        for (int v = 0; v < NV; v++) cand_tab[v] = ~tgt[v];
        scenario("inverted", 4'd3, -1, -1);

        // mixed rows
        for (int v = 0; v < NV; v++) cand_tab[v] = (v % 3 == 0) ? tgt[v] : NO'(v);
        scenario("mixed", 4'd7, -1, -1);

        // R9 largest wire count on an exact candidate
        for (int v = 0; v < NV; v++) cand_tab[v] = tgt[v];
        scenario("max wires R9", {WW{1'b1}}, -1, -1);

        // R8 start while busy, R5 wire count changing mid-run
        scenario("start while busy R8", 4'd2, 6, 4);

        // start in a row, mid-run start on a partial candidate
        cand_tab[2] = ~tgt[2];
        scenario("partial R8", 4'd1, 9, 3);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule